// File: doc/BRIEF.md
# Shift-Register FIFO Queue

This block is a first-in-first-out queue whose entries live in a chain of word-wide shift-register stages rather than in addressed memory. Every accepted write pushes the whole chain one stage deeper and drops the new word into stage 0. Reads take the oldest entry from the far end of the occupied part of the chain.

An up-down counter tracks how many entries are valid. It goes up on an accepted write, down on an accepted read, and stays put when both happen in the same cycle. The same count drives the full and empty flags and selects which stage holds the oldest word. That word is shown on the read port ahead of the read (show-ahead), so a read strobe acknowledges the word already on `rd_data`. Writes that would overflow and reads that would underflow are dropped.

Top module: `shift_queue`

## Requirements
- R1: After synchronous reset, `count` is 0, `empty` is 1 and `full` is 0.
- R2: A write with `full` low and no read is accepted, and `count` rises by one after the clock edge.
- R3: Words leave in the order they were written. For example, holding 23 (oldest) then 34, a write of 45 gives the contents 23, 34, 45.
- R4: A read with `empty` low and no write removes the oldest word and lowers `count` by one. The next-oldest word then appears on `rd_data`. In the R3 example, the read returns 23 and leaves 34, 45.
- R5: `full` is 1 exactly when `count` equals DEPTH, and `empty` is 1 exactly when `count` is 0.
- R6: A write while `full` is high with no read is ignored. `count` and the stored words are unchanged.
- R7: A read while `empty` is high is ignored. `count` stays at 0 and `empty` stays high.
- R8: A read and a write in the same cycle with `empty` low both take effect, including when `full` is high. `count` is unchanged, the old oldest word is removed, and the new word becomes the youngest.
- R9: A read and a write in the same cycle while `empty` is high behave as a lone write, so `count` becomes 1.
- R10: `rd_data` equals the oldest stored word whenever `empty` is low, and is all zeros whenever `empty` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request: store `wr_data` |
| wr_data | input | WIDTH | Word to store |
| rd_en | input | 1 | Read request: remove the word shown on `rd_data` |
| rd_data | output | WIDTH | Oldest stored word (zero when empty) |
| full | output | 1 | Queue holds DEPTH words |
| empty | output | 1 | Queue holds no words |
| count | output | $clog2(DEPTH+1) | Number of stored words |

## Verification
`count`, `full` and `empty` are registers, so a request presented in one cycle shows on them one rising edge later. `rd_data` is decoded from registered state, so it changes at that same edge. The bench drives each request on a falling edge and waits through exactly one rising edge. It then compares every output with an arithmetic queue model at the following falling edge, before the next request is driven. The sweep starts from every fill level, applies each of the four request combinations, then drains the queue so that any dropped or reordered word shows up on `rd_data`.

// File: rtl/shift_queue_pkg.sv
package shift_queue_pkg;

  // Encoding is {read accepted, write accepted}
  typedef enum logic [1:0] {
    SQ_IDLE = 2'b00,
    SQ_PUSH = 2'b01,
    SQ_POP  = 2'b10,
    SQ_SWAP = 2'b11
  } sq_op_e;

endpackage

// File: rtl/sq_op_decode.sv
module sq_op_decode
  import shift_queue_pkg::*;
(
  input  logic   wr_en,
  input  logic   rd_en,
  input  logic   full,
  input  logic   empty,
  output sq_op_e op
);

  logic rd_ok;
  logic wr_ok;

  // A read frees the far stage in the same edge, so a full queue may still take a write alongside it.
  always_comb begin
    rd_ok = rd_en & ~empty;
    wr_ok = wr_en & (~full | rd_ok);
    op    = sq_op_e'({rd_ok, wr_ok});
  end

endmodule

// File: rtl/sq_occupancy.sv
module sq_occupancy
  import shift_queue_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  sq_op_e        op,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);

  localparam logic [CW-1:0] LIMIT = CW'(DEPTH);

  logic [CW-1:0] cnt_nxt;

  always_comb begin
    case (op)
      SQ_PUSH: cnt_nxt = count + 1'b1;
      SQ_POP:  cnt_nxt = count - 1'b1;
      default: cnt_nxt = count;
    endcase
  end

  // Flags are registered from the next count so they never lag the counter.
  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      full  <= 1'b0;
      empty <= 1'b1;
    end else begin
      count <= cnt_nxt;
      full  <= (cnt_nxt == LIMIT);
      empty <= (cnt_nxt == '0);
    end
  end

endmodule

// File: rtl/sq_stage_chain.sv
module sq_stage_chain #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             shift_in,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [CW-1:0]    count,
  output logic [WIDTH-1:0] rd_data
);

  logic [WIDTH-1:0] stg [DEPTH];

  // No reset on the data stages: they are qualified by count, and a reset-free chain maps onto shift-register primitives.
  always_ff @(posedge clk) begin
    if (shift_in) stg[0] <= wr_data;
  end

  for (genvar g = 1; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (shift_in) stg[g] <= stg[g-1];
    end
  end

  // The oldest word sits in stage count-1; nothing is selected when count is zero.
  always_comb begin
    rd_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (count == CW'(i + 1)) rd_data = stg[i];
    end
  end

endmodule

// File: rtl/shift_queue.sv
module shift_queue
  import shift_queue_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             full,
  output logic             empty,
  output logic [CW-1:0]    count
);

  sq_op_e op;
  logic   shift_in;

  sq_op_decode i_decode (
    .wr_en (wr_en),
    .rd_en (rd_en),
    .full  (full),
    .empty (empty),
    .op    (op)
  );

  sq_occupancy #(.DEPTH(DEPTH), .CW(CW)) i_occ (
    .clk   (clk),
    .rst   (rst),
    .op    (op),
    .count (count),
    .full  (full),
    .empty (empty)
  );

  // Any accepted write, alone or paired with a read, moves the chain.
  assign shift_in = (op == SQ_PUSH) || (op == SQ_SWAP);

  sq_stage_chain #(.WIDTH(WIDTH), .DEPTH(DEPTH), .CW(CW)) i_chain (
    .clk      (clk),
    .shift_in (shift_in),
    .wr_data  (wr_data),
    .count    (count),
    .rd_data  (rd_data)
  );

endmodule

// File: rtl/sq_checker.sv
module sq_checker #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             rd_en,
  input logic [WIDTH-1:0] rd_data,
  input logic             full,
  input logic             empty,
  input logic [CW-1:0]    count
);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) count <= CW'(DEPTH)); // R2
  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (rst) (wr_en && !rd_en && !full) |=> (count == $past(count) + 1'b1)); // R2
  AST_POP_STEP: assert property (@(posedge clk) disable iff (rst) (rd_en && !wr_en && !empty) |=> (count == $past(count) - 1'b1)); // R4
  AST_FULL_FLAG: assert property (@(posedge clk) disable iff (rst) full == (count == CW'(DEPTH))); // R5
  AST_EMPTY_FLAG: assert property (@(posedge clk) disable iff (rst) empty == (count == '0)); // R5
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (rst) (wr_en && !rd_en && full) |=> (full && $stable(count))); // R6
  AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (rst) (rd_en && !wr_en && empty) |=> empty); // R7
  AST_SWAP_COUNT: assert property (@(posedge clk) disable iff (rst) (wr_en && rd_en && !empty) |=> $stable(count)); // R8
  AST_EMPTY_SWAP: assert property (@(posedge clk) disable iff (rst) (wr_en && rd_en && empty) |=> (count == CW'(1))); // R9
  AST_ZERO_OUT: assert property (@(posedge clk) disable iff (rst) empty |-> (rd_data == '0)); // R10

endmodule

bind shift_queue sq_checker #(.WIDTH(WIDTH), .DEPTH(DEPTH), .CW(CW)) i_sq_checker (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .rd_data (rd_data),
  .full    (full),
  .empty   (empty),
  .count   (count)
);

// File: tb/test_shift_queue.sv
module test_shift_queue;

  localparam int WIDTH = 8;
  localparam int DEPTH = 4;
  localparam int CW    = $clog2(DEPTH + 1);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wr_en = 1'b0;
  logic             rd_en = 1'b0;
  logic [WIDTH-1:0] wr_data = '0;
  logic [WIDTH-1:0] rd_data;
  logic             full;
  logic             empty;
  logic [CW-1:0]    count;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  logic [WIDTH-1:0] m [DEPTH];   // m[0] is the oldest word
  int               mc;

  always #10 clk = ~clk;

  shift_queue #(.WIDTH(WIDTH), .DEPTH(DEPTH)) i_shift_queue (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .full(full), .empty(empty), .count(count)
  );

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " count"}, int'(count), mc);
    chk("R5 full", int'(full), int'(mc == DEPTH));
    chk("R5 empty", int'(empty), int'(mc == 0));
    chk(mc == 0 ? "R10 rd_data" : "R3 rd_data", int'(rd_data), mc == 0 ? 0 : int'(m[0]));
  endtask

  // Drive on the falling edge, let one rising edge act, check on the next falling edge.
  task automatic op(input bit w, input bit r, input logic [WIDTH-1:0] d, input string tag);
    bit rok, wok;
    @(negedge clk);
    wr_en = w; rd_en = r; wr_data = d;
    @(posedge clk);
    rok = r && (mc > 0);
    wok = w && ((mc < DEPTH) || rok);
    if (rok) begin
      for (int i = 0; i < DEPTH - 1; i++) m[i] = m[i+1];
      mc--;
    end
    if (wok) begin
      m[mc] = d;
      mc++;
    end
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check_all(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    mc = 0;
    check_all("R1");
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    end
    $finish;
  end

  initial begin
    logic [7:0] lfsr;
    mc = 0;
    do_reset();

    // Worked example: 23, 34, then 45, then one read
    op(1, 0, 8'd23, "R2");
    op(1, 0, 8'd34, "R2");
    op(1, 0, 8'd45, "R3");
    chk("R3 oldest", int'(rd_data), 23);
    op(0, 1, 8'd0, "R4");
    chk("R4 next oldest", int'(rd_data), 34);
    chk("R4 count", int'(count), 2);

    // Every fill level against every request pair, then a full drain
    for (int lvl = 0; lvl <= DEPTH; lvl++) begin
      for (int k = 0; k < 4; k++) begin
        do_reset();
        for (int j = 0; j < lvl; j++) op(1, 0, 8'(8'h10 * lvl + j + 1), "R2");
        case (k)
          0: op(0, 0, 8'hEE, "R5");
          1: op(1, 0, 8'hA5, lvl == DEPTH ? "R6" : "R2");
          2: op(0, 1, 8'hEE, lvl == 0 ? "R7" : "R4");
          default: op(1, 1, 8'h5A, lvl == 0 ? "R9" : "R8");
        endcase
        while (mc > 0) op(0, 1, 8'h00, "R4");
        op(0, 1, 8'h00, "R7");
      end
    end

    // Long pseudo-random run against the model
    do_reset();
    lfsr = 8'hB7;
    for (int n = 0; n < 3000; n++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      op(lfsr[0], lfsr[3] & (lfsr[1] | lfsr[5]), lfsr ^ 8'h3C,
         (lfsr[0] && lfsr[3]) ? "R8" : "R3");
    end

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    end
    $finish;
  end

endmodule